// File: doc/BRIEF.md
# Two-Bus Synchronous Static Memory with Cross-Port Streaming

This block is a synchronous word memory with two separate data buses sharing one address: a processor-side port and a system-side port. Each port has its own input enable, which decides whether the word on that bus is captured, and its own output enable, which gates that bus's driver with no clock involved. A word captured on one port can be sent straight out of the other port without passing through the array. The array can take a write in the same cycle. Each bidirectional bus is split into an input vector, an output vector and a drive-enable, so the block fits behind any pad ring.

Controls and data are captured on the rising clock edge. The address is captured on the following falling edge, and the write happens at that edge, so it is finished well inside the cycle. Each output goes through a latch that follows its source while the clock is high and holds while the clock is low. A parameter selects a separate-I/O variant in which the processor bus is input only and the system bus is output only.

Top module: `dual_bus_sram`

## Requirements
- R1: While `rst_n` is low, both output vectors read zero, and no write happens until a rising edge with `rst_n` high has captured a write request.
- R2: `p_d_oe` equals `p_out_en` and `s_d_oe` equals `s_out_en` at all times, changing with no clock edge (separate-I/O variant: `p_d_oe` stays 0).
- R3: The address used by a cycle is the value on `addr` at the falling clock edge, not at the rising edge.
- R4: `wr_en`, both input enables and both input buses are sampled on the rising edge only; changing them later in the same cycle has no effect on that cycle.
- R5: A cycle with `wr_en` and at least one input enable captured stores the selected 9-bit word (bit 8 parity, bits 7:0 data) at its address; in the next cycle, reading that address returns the new word on both ports.
- R6: `wr_en` captured with neither input enable, or an input enable captured without `wr_en`, leaves the array unchanged.
- R7: When both input enables are captured in a write cycle, the processor port's word is stored.
- R8: During the high phase after a rising edge that captured one port's input enable, the other port's output shows the word that port captured; with no such enable it shows the array word at the address captured at the previous falling edge.
- R9: Each output latch is transparent while the clock is high and holds its value through the low phase even when its source changes.
- R10: A write and a stream in either direction may happen in the same cycle, both producing their normal results.
- R11: With `SEP_IO` set, `s_in_en` and `p_out_en` are ignored and the processor input enable follows `wr_en`; a write stores the processor word and streams it to the system port.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; rising edge samples controls and data, falling edge samples address and writes |
| rst_n | input | 1 | Asynchronous active-low reset of registers and output latches |
| addr | input | ADDR_W | Word address, sampled on the falling edge |
| wr_en | input | 1 | Write request, active high |
| p_in_en | input | 1 | Processor bus capture enable, active high |
| s_in_en | input | 1 | System bus capture enable, active high |
| p_out_en | input | 1 | Processor bus drive enable, asynchronous |
| s_out_en | input | 1 | System bus drive enable, asynchronous |
| p_d_in | input | DATA_W+PAR_W | Processor bus input word |
| p_d_out | output | DATA_W+PAR_W | Processor bus output word |
| p_d_oe | output | 1 | Processor bus driver enable |
| s_d_in | input | DATA_W+PAR_W | System bus input word |
| s_d_out | output | DATA_W+PAR_W | System bus output word |
| s_d_oe | output | 1 | System bus driver enable |

## Verification
An array write and a cross-port stream can fall in the same cycle, and so can captures from both buses. The bench provokes this with cycles that raise `wr_en` together with one or both input enables. In the high phase of that cycle it checks that the opposite port shows the captured word. One cycle later it reads the address back and judges it against the word that should have been stored, with the processor word taking priority when both enables are set.

// File: rtl/dbs_pkg.sv
package dbs_pkg;
   localparam int PORT_P  = 0;
   localparam int PORT_S  = 1;
   localparam int N_PORTS = 2;

   function automatic int peer_of(input int idx);
      return (idx == PORT_P) ? PORT_S : PORT_P;
   endfunction
endpackage

// File: rtl/dbs_in_reg.sv
module dbs_in_reg #(
   parameter int W = 9
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         en_i,
   input  logic [W-1:0] d_i,
   output logic         en_q,
   output logic [W-1:0] d_q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q <= 1'b0;
         d_q  <= '0;
      end else begin
         en_q <= en_i;
         d_q  <= d_i;
      end
   end
endmodule

// File: rtl/dbs_out_latch.sv
module dbs_out_latch #(
   parameter int W = 9
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] src_i,
   output logic [W-1:0] q_o
);
   always_latch begin
      if (!rst_n)   q_o = '0;
      else if (clk) q_o = src_i;
   end
endmodule

// File: rtl/dbs_array.sv
module dbs_array #(
   parameter int W      = 9,
   parameter int DEPTH  = 1024,
   parameter int ADDR_W = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              we_i,
   input  logic [ADDR_W-1:0] waddr_i,
   input  logic [W-1:0]      wdata_i,
   input  logic [ADDR_W-1:0] raddr_i,
   output logic [W-1:0]      rdata_o
);
   logic [W-1:0] cells [DEPTH];

   // write completes at the falling edge, inside the cycle
   always_ff @(negedge clk) begin
      if (we_i) cells[waddr_i] <= wdata_i;
   end

   assign rdata_o = cells[raddr_i];
endmodule

// File: rtl/dual_bus_sram.sv
module dual_bus_sram
   import dbs_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int PAR_W  = 1,
   parameter int DEPTH  = 1024,
   parameter int ADDR_W = $clog2(DEPTH),
   parameter bit SEP_IO = 1'b0
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic [ADDR_W-1:0]       addr,
   input  logic                    wr_en,
   input  logic                    p_in_en,
   input  logic                    s_in_en,
   input  logic                    p_out_en,
   input  logic                    s_out_en,
   input  logic [DATA_W+PAR_W-1:0] p_d_in,
   output logic [DATA_W+PAR_W-1:0] p_d_out,
   output logic                    p_d_oe,
   input  logic [DATA_W+PAR_W-1:0] s_d_in,
   output logic [DATA_W+PAR_W-1:0] s_d_out,
   output logic                    s_d_oe
);
   localparam int WORD_W = DATA_W + PAR_W;

   // elaboration-time parameter checks
   if (DATA_W < 1) begin : g_bad_data_w
      $error("DATA_W must be at least 1");
   end
   if (PAR_W < 0) begin : g_bad_par_w
      $error("PAR_W must not be negative");
   end
   if (DEPTH < 2 || (1 << ADDR_W) != DEPTH) begin : g_bad_depth
      $error("DEPTH must be a power of two, at least 2, matching ADDR_W");
   end

   logic              ie_raw [N_PORTS];
   logic [WORD_W-1:0] din_raw[N_PORTS];
   logic              ie_q   [N_PORTS];
   logic [WORD_W-1:0] din_q  [N_PORTS];
   logic [WORD_W-1:0] lat_q  [N_PORTS];
   logic [WORD_W-1:0] lat_src[N_PORTS];

   logic              wr_q;
   logic [ADDR_W-1:0] addr_q;
   logic              arr_we;
   logic [WORD_W-1:0] arr_wdata;
   logic [WORD_W-1:0] arr_rdata;

   // variant selection: shared buses or separate input/output buses
   if (SEP_IO) begin : g_sep_io
      assign ie_raw[PORT_P] = wr_en;
      assign ie_raw[PORT_S] = 1'b0;
      assign p_d_oe         = 1'b0;
   end else begin : g_shared_io
      assign ie_raw[PORT_P] = p_in_en;
      assign ie_raw[PORT_S] = s_in_en;
      assign p_d_oe         = p_out_en;
   end
   assign s_d_oe = s_out_en;

   assign din_raw[PORT_P] = p_d_in;
   assign din_raw[PORT_S] = s_d_in;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) wr_q <= 1'b0;
      else        wr_q <= wr_en;
   end

   always_ff @(negedge clk or negedge rst_n) begin
      if (!rst_n) addr_q <= '0;
      else        addr_q <= addr;
   end

   for (genvar g = 0; g < N_PORTS; g++) begin : g_port
      dbs_in_reg #(.W(WORD_W)) u_in (
         .clk   (clk),
         .rst_n (rst_n),
         .en_i  (ie_raw[g]),
         .d_i   (din_raw[g]),
         .en_q  (ie_q[g]),
         .d_q   (din_q[g])
      );

      // stream from the peer's input register, else read the array
      assign lat_src[g] = ie_q[peer_of(g)] ? din_q[peer_of(g)] : arr_rdata;

      dbs_out_latch #(.W(WORD_W)) u_lat (
         .clk   (clk),
         .rst_n (rst_n),
         .src_i (lat_src[g]),
         .q_o   (lat_q[g])
      );
   end

   assign p_d_out = lat_q[PORT_P];
   assign s_d_out = lat_q[PORT_S];

   // processor port wins when both captured
   assign arr_we    = rst_n && wr_q && (ie_q[PORT_P] || ie_q[PORT_S]);
   assign arr_wdata = ie_q[PORT_P] ? din_q[PORT_P] : din_q[PORT_S];

   dbs_array #(.W(WORD_W), .DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_array (
      .clk     (clk),
      .we_i    (arr_we),
      .waddr_i (addr),
      .wdata_i (arr_wdata),
      .raddr_i (addr_q),
      .rdata_o (arr_rdata)
   );
endmodule

// File: rtl/dbs_checker.sv
module dbs_checker #(
   parameter int DATA_W = 8,
   parameter int PAR_W  = 1,
   parameter int ADDR_W = 10,
   parameter bit SEP_IO = 1'b0
) (
   input logic                    clk,
   input logic                    rst_n,
   input logic                    wr_en,
   input logic                    p_in_en,
   input logic                    s_in_en,
   input logic                    p_out_en,
   input logic                    s_out_en,
   input logic [DATA_W+PAR_W-1:0] p_d_in,
   input logic [DATA_W+PAR_W-1:0] s_d_in,
   input logic [DATA_W+PAR_W-1:0] p_d_out,
   input logic [DATA_W+PAR_W-1:0] s_d_out,
   input logic                    p_d_oe,
   input logic                    s_d_oe
);
   localparam int W = DATA_W + PAR_W;

   logic         pie_eff, sie_eff;
   logic         wr_s, pie_s, sie_s;
   logic [W-1:0] pd_s, sd_s;
   logic         lw_v, fall_seen;
   logic [W-1:0] lw_d, p_hold, s_hold;

   assign pie_eff = SEP_IO ? wr_en : p_in_en;
   assign sie_eff = SEP_IO ? 1'b0  : s_in_en;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_s <= 1'b0; pie_s <= 1'b0; sie_s <= 1'b0;
         pd_s <= '0;   sd_s  <= '0;
      end else begin
         wr_s <= wr_en; pie_s <= pie_eff; sie_s <= sie_eff;
         pd_s <= p_d_in; sd_s <= s_d_in;
      end
   end

   always_ff @(negedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lw_v <= 1'b0; lw_d <= '0; fall_seen <= 1'b0;
         p_hold <= '0; s_hold <= '0;
      end else begin
         lw_v      <= wr_s && (pie_s || sie_s);
         lw_d      <= pie_s ? pd_s : sd_s;
         fall_seen <= 1'b1;
         p_hold    <= p_d_out;
         s_hold    <= s_d_out;
      end
   end

   AST_OE_TRACKS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
      (p_d_oe == (p_out_en && !SEP_IO)) && (s_d_oe == s_out_en)); // R2

   AST_LATCH_HOLDS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      fall_seen |-> ((p_d_out === p_hold) && (s_d_out === s_hold))); // R9

   AST_STREAM_P_TO_S: assert property (@(negedge clk) disable iff (!rst_n)
      pie_s |-> (s_d_out === pd_s)); // R8

   AST_STREAM_S_TO_P: assert property (@(negedge clk) disable iff (!rst_n)
      sie_s |-> (p_d_out === sd_s)); // R8

   AST_WRITE_READBACK: assert property (@(negedge clk) disable iff (!rst_n)
      (lw_v && !sie_s) |-> (p_d_out === lw_d)); // R5
endmodule

bind dual_bus_sram dbs_checker #(
   .DATA_W (DATA_W),
   .PAR_W  (PAR_W),
   .ADDR_W (ADDR_W),
   .SEP_IO (SEP_IO)
) u_chk (.*);

// File: tb/tb_dual_bus_sram.sv
module tb_dual_bus_sram;
   localparam int CLK_PERIOD = 10;
   localparam int DATA_W = 8;
   localparam int PAR_W  = 1;
   localparam int DEPTH  = 1024;
   localparam int ADDR_W = 10;
   localparam int W      = DATA_W + PAR_W;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic [ADDR_W-1:0] addr = '0;
   logic              wr_en = 1'b0, p_in_en = 1'b0, s_in_en = 1'b0;
   logic              p_out_en = 1'b1, s_out_en = 1'b1;
   logic [W-1:0]      p_d_in = '0, s_d_in = '0;
   logic [W-1:0]      p_d_out, s_d_out, sp_d_out, ss_d_out;
   logic              p_d_oe, s_d_oe, sp_d_oe, ss_d_oe;

   int n_checks = 0;
   int n_fail   = 0;
   bit finished = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   dual_bus_sram #(.DATA_W(DATA_W), .PAR_W(PAR_W), .DEPTH(DEPTH),
                   .ADDR_W(ADDR_W), .SEP_IO(1'b0)) dut (
      .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en),
      .p_in_en(p_in_en), .s_in_en(s_in_en),
      .p_out_en(p_out_en), .s_out_en(s_out_en),
      .p_d_in(p_d_in), .p_d_out(p_d_out), .p_d_oe(p_d_oe),
      .s_d_in(s_d_in), .s_d_out(s_d_out), .s_d_oe(s_d_oe));

   dual_bus_sram #(.DATA_W(DATA_W), .PAR_W(PAR_W), .DEPTH(DEPTH),
                   .ADDR_W(ADDR_W), .SEP_IO(1'b1)) dut_sep (
      .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en),
      .p_in_en(p_in_en), .s_in_en(s_in_en),
      .p_out_en(p_out_en), .s_out_en(s_out_en),
      .p_d_in(p_d_in), .p_d_out(sp_d_out), .p_d_oe(sp_d_oe),
      .s_d_in(s_d_in), .s_d_out(ss_d_out), .s_d_oe(ss_d_oe));

   task automatic check(input string req, input string what,
                        input logic [W-1:0] act, input logic [W-1:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   // drive one cycle after a falling edge, stop in the next high phase
   task automatic step(input logic [ADDR_W-1:0] a, input logic w,
                       input logic pie, input logic sie,
                       input logic [W-1:0] pd, input logic [W-1:0] sd);
      @(negedge clk); #1;
      addr = a; wr_en = w; p_in_en = pie; s_in_en = sie;
      p_d_in = pd; s_d_in = sd;
      @(posedge clk); #2;
   endtask

   task automatic idle(input logic [ADDR_W-1:0] a);
      step(a, 1'b0, 1'b0, 1'b0, 9'h000, 9'h000);
   endtask

   task automatic t_reset();
      #7;
      check("R1", "p out in reset", p_d_out, 9'h000);
      check("R1", "s out in reset", s_d_out, 9'h000);
      @(negedge clk); #1 rst_n = 1'b1;
   endtask

   task automatic t_oe();
      @(negedge clk); #1 p_out_en = 1'b0;
      #1 check("R2", "p oe low", {8'h0, p_d_oe}, 9'h000);
      p_out_en = 1'b1;
      #1 check("R2", "p oe high", {8'h0, p_d_oe}, 9'h001);
      s_out_en = 1'b0;
      #1 check("R2", "s oe low", {8'h0, s_d_oe}, 9'h000);
      s_out_en = 1'b1;
      #1 check("R2", "s oe high", {8'h0, s_d_oe}, 9'h001);
      check("R11", "sep p oe forced off", {8'h0, sp_d_oe}, 9'h000);
   endtask

   task automatic t_write_ports();
      step(10'd5, 1'b1, 1'b1, 1'b0, 9'h1A5, 9'h000);
      idle(10'd0);
      check("R5", "p read after p write", p_d_out, 9'h1A5);
      check("R5", "s read after p write", s_d_out, 9'h1A5);
      step(10'd9, 1'b1, 1'b0, 1'b1, 9'h000, 9'h0C3);
      idle(10'd0);
      check("R5", "p read after s write", p_d_out, 9'h0C3);
      check("R5", "s read after s write", s_d_out, 9'h0C3);
   endtask

   task automatic t_priority();
      step(10'd12, 1'b1, 1'b1, 1'b1, 9'h111, 9'h022);
      check("R8", "p shows s word", p_d_out, 9'h022);
      check("R8", "s shows p word", s_d_out, 9'h111);
      idle(10'd0);
      check("R7", "both enables store p word", p_d_out, 9'h111);
   endtask

   task automatic t_no_write();
      step(10'd5, 1'b1, 1'b0, 1'b0, 9'h0FF, 9'h0FF);
      step(10'd9, 1'b0, 1'b1, 1'b0, 9'h1FF, 9'h000);
      check("R6", "wr without enable keeps word", p_d_out, 9'h1A5);
      idle(10'd0);
      check("R6", "enable without wr keeps word", s_d_out, 9'h0C3);
   endtask

   task automatic t_stream();
      step(10'd0, 1'b0, 1'b1, 1'b0, 9'h155, 9'h000);
      check("R8", "stream p to s", s_d_out, 9'h155);
      step(10'd0, 1'b0, 1'b0, 1'b1, 9'h000, 9'h0AB);
      check("R8", "stream s to p", p_d_out, 9'h0AB);
   endtask

   task automatic t_write_stream();
      step(10'd20, 1'b1, 1'b1, 1'b0, 9'h0AA, 9'h000);
      check("R10", "stream during write", s_d_out, 9'h0AA);
      idle(10'd0);
      check("R10", "write during stream stored", p_d_out, 9'h0AA);
   endtask

   task automatic t_addr_fall();
      @(negedge clk); #1;
      addr = 10'd5; wr_en = 1'b0; p_in_en = 1'b0; s_in_en = 1'b0;
      @(posedge clk); #2 addr = 10'd9;
      idle(10'd0);
      check("R3", "address from falling edge", p_d_out, 9'h0C3);
   endtask

   task automatic t_ctrl_rise();
      @(negedge clk); #1;
      addr = 10'd12; wr_en = 1'b1; p_in_en = 1'b1; p_d_in = 9'h033;
      @(posedge clk); #2;
      wr_en = 1'b0; p_in_en = 1'b0; p_d_in = 9'h1EE;
      idle(10'd0);
      check("R4", "late deassert keeps captured write", p_d_out, 9'h033);
      @(negedge clk); #1 addr = 10'd20;
      @(posedge clk); #2;
      wr_en = 1'b1; p_in_en = 1'b1; p_d_in = 9'h111;
      idle(10'd0);
      check("R4", "late assert writes nothing", s_d_out, 9'h0AA);
   endtask

   task automatic t_latch_hold();
      idle(10'd5);
      idle(10'd9);
      check("R9", "transparent in high phase", p_d_out, 9'h1A5);
      @(negedge clk); #2;
      check("R9", "held in low phase", p_d_out, 9'h1A5);
      @(posedge clk); #2;
      check("R9", "follows new source", s_d_out, 9'h0C3);
   endtask

   task automatic t_sep();
      step(10'd30, 1'b1, 1'b0, 1'b1, 9'h077, 9'h0EE);
      check("R11", "sep streams p word on write", ss_d_out, 9'h077);
      idle(10'd0);
      check("R11", "sep stores p word", ss_d_out, 9'h077);
      check("R11", "shared stores s word", s_d_out, 9'h0EE);
   endtask

   task automatic report();
      if (!finished) begin
         finished = 1'b1;
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
         $finish;
      end
   endtask

   initial begin
      t_reset();
      t_oe();
      t_write_ports();
      t_priority();
      t_no_write();
      t_stream();
      t_write_stream();
      t_addr_fall();
      t_ctrl_rise();
      t_latch_hold();
      t_sep();
      repeat (2) @(posedge clk);
      report();
   end

   initial begin
      #(CLK_PERIOD * 5000);
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      report();
   end
endmodule